// File: doc/BRIEF.md
# Repeater status and utilization LED panel

This block turns the status flags of a four-port repeater into the levels of its indicator LEDs. Each port has an activity LED and an error LED. The port's signal, lock, receive, fault and symbol-error flags select whether each LED is dark, steadily lit or blinking. A collision LED blinks whenever a collision is reported, either on this unit or elsewhere in the stack. A five-LED bar shows how much of the time the medium was busy during the last measurement window.

All LED outputs are active low. Every LED passes through a hold stage, so that no LED can change state again until a minimum number of millisecond ticks has gone by since its last change. A blink is a pulse that is one hold period long. While its condition lasts, the pulse repeats after a gap of the same length. Utilization is the number of clock cycles with the busy flag high, counted over a window of a fixed number of cycles. The bar is refreshed only when a window closes.

Top module: `hub_led_panel`

## Requirements
- R1: While reset is asserted and just after it is released, every LED output is high (dark). A low output lights an LED.
- R2: After any LED output changes, it keeps its new level until at least HOLD_MS rising edges with `ms_tick` high have passed.
- R3: A port whose `sig_det` is low shows both its activity LED and its error LED dark.
- R4: A port with `sig_det` high and `idle_lock` low keeps its activity LED dark, and its error LED blinks on.
- R5: A linked port (`sig_det` and `idle_lock` high) with no fault lights its activity LED. While `rx_act` is high, the activity LED blinks dark.
- R6: A linked port with `port_fault` high (partitioned, isolated or jabber-disabled) shows both LEDs steadily lit.
- R7: A linked, non-faulted port with `bad_sym` high blinks its error LED on. Otherwise its error LED is dark.
- R8: Bar LED k (bit k of `util_led_n`, with bit 0 the lowest step) is lit when the busy fraction of the last window is above 1%, 12.5%, 25%, 50% and 60% for k = 0 to 4. A fraction exactly on a threshold does not light that step.
- R9: The bar is computed from the busy count of each complete window of WIN_CYCLES cycles, including the last cycle of the window. It changes only after a window closes.
- R10: A pulse on `coll_local` or on `coll_stack` lights the collision LED. With no collisions, the collision LED returns to dark.
- R11: A blink is a lit (or dark) pulse of HOLD_MS ticks. While its condition stays true, the pulse repeats after a gap of HOLD_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| sig_det | input | NPORT | Per-port incoming signal present |
| idle_lock | input | NPORT | Per-port descrambler locked on idle |
| rx_act | input | NPORT | Per-port packet being received |
| port_fault | input | NPORT | Per-port partition, isolation or jabber shutdown |
| bad_sym | input | NPORT | Per-port false carrier or invalid data |
| coll_local | input | 1 | Collision on this unit |
| coll_stack | input | 1 | Collision elsewhere in the stack |
| net_busy | input | 1 | Medium busy in this cycle |
| act_led_n | output | NPORT | Per-port activity LED, active low |
| err_led_n | output | NPORT | Per-port error LED, active low |
| coll_led_n | output | 1 | Collision LED, active low |
| util_led_n | output | 5 | Utilization bar, active low, bit 0 lowest |

## Verification
Closing a window and counting a busy cycle fall in the same cycle: the busy flag in the last cycle of a window must still be added to the total that the bar is computed from. The bench drives busy patterns whose period divides the window length, so every window holds an exact count whatever its phase. It then checks the counts that land exactly on 1%, 12.5%, 25%, 50% and 60% against the counts one step above them. A count that lost the last cycle, or one that leaked into the next window, moves the result across a threshold. A second overlap is a hold expiring in the same cycle that a blink requests a change. This is judged by a monitor that counts the ticks between every pair of output changes.

// File: rtl/hub_led_pkg.sv
package hub_led_pkg;

  localparam int NBAR = 5;

  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_MARK  = 2'd1,
    FL_SPACE = 2'd2
  } flash_st_t;

  // step k of the utilization bar: busy/win above a fixed fraction
  function automatic logic util_above(input longint busy, input longint win, input int step);
    case (step)
      0:       return (busy * 100) > win;
      1:       return (busy * 8) > win;
      2:       return (busy * 4) > win;
      3:       return (busy * 2) > win;
      default: return (busy * 5) > (win * 3);
    endcase
  endfunction

endpackage

// File: rtl/led_flash.sv
module led_flash
  import hub_led_pkg::*;
#(
  parameter int HOLD_MS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic cond,
  output logic pulse
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  flash_st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= FL_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        FL_IDLE: begin
          if (cond) begin
            st  <= FL_MARK;
            cnt <= '0;
          end
        end
        FL_MARK: begin
          if (ms_tick) begin
            if (cnt == LAST) begin
              st  <= FL_SPACE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FL_SPACE: begin
          if (ms_tick) begin
            if (cnt == LAST) begin
              st  <= cond ? FL_MARK : FL_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          st  <= FL_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign pulse = (st == FL_MARK);

  // R11: a pulse only starts while its condition is present
  assert_pulse_needs_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(cond));

  // R11: a pulse only ends on a tick
  assert_pulse_ends_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> $past(ms_tick));

endmodule

// File: rtl/led_hold.sv
module led_hold #(
  parameter int HOLD_MS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic want,
  output logic led_n
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_MS);

  logic lit;
  logic [CW-1:0] age;
  logic ripe;

  assign ripe = (age == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit <= 1'b0;
      age <= FULL;
    end else if (ripe && (want != lit)) begin
      lit <= want;
      age <= '0;
    end else if (ms_tick && !ripe) begin
      age <= age + 1'b1;
    end
  end

  assign led_n = ~lit;

  // R2: a level change is only allowed once the full hold has elapsed
  assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lit != $past(lit)) |-> ($past(age) == FULL));

  // R2: age never runs past the hold length
  assert_age_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    age <= FULL);

endmodule

// File: rtl/port_led_map.sv
module port_led_map #(
  parameter int HOLD_MS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic sig_det,
  input  logic idle_lock,
  input  logic rx_act,
  input  logic port_fault,
  input  logic bad_sym,
  output logic act_want,
  output logic err_want
);
  logic linked, faulted, healthy;
  logic act_cond, err_cond;
  logic act_pulse, err_pulse;

  assign linked  = sig_det & idle_lock;
  assign faulted = linked & port_fault;
  assign healthy = linked & ~port_fault;

  // R4 / R7: the error blink covers both lock loss and bad symbols
  assign err_cond = (sig_det & ~idle_lock) | (healthy & bad_sym);
  // R5: the activity blink runs while receiving
  assign act_cond = healthy & rx_act;

  led_flash #(.HOLD_MS(HOLD_MS)) u_act_flash (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cond(act_cond), .pulse(act_pulse)
  );

  led_flash #(.HOLD_MS(HOLD_MS)) u_err_flash (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cond(err_cond), .pulse(err_pulse)
  );

  assign act_want = linked & (port_fault | ~act_pulse);
  assign err_want = sig_det & (faulted | err_pulse);

  // R3: no signal keeps both LEDs dark
  assert_dark_nosig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |-> (!act_want && !err_want));

  // R6: a fault on a linked port requests both LEDs lit
  assert_fault_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    faulted |-> (act_want && err_want));

  // R4: without lock the activity LED is never requested
  assert_nolock_act_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det && !idle_lock) |-> !act_want);

endmodule

// File: rtl/util_meter.sv
module util_meter
  import hub_led_pkg::*;
#(
  parameter int WIN_CYCLES = 2500000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            net_busy,
  output logic [NBAR-1:0] bar_want
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LASTPOS = CW'(WIN_CYCLES - 1);

  logic [CW-1:0]   pos;
  logic [CW-1:0]   busy_cnt;
  logic [CW-1:0]   total;
  logic            last;
  logic [NBAR-1:0] level;

  assign last  = (pos == LASTPOS);
  assign total = busy_cnt + CW'(net_busy);

  for (genvar k = 0; k < NBAR; k++) begin : g_step
    assign level[k] = util_above(longint'(total), longint'(WIN_CYCLES), k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      busy_cnt <= '0;
      bar_want <= '0;
    end else if (last) begin
      pos      <= '0;
      busy_cnt <= '0;
      bar_want <= level;
    end else begin
      pos      <= pos + 1'b1;
      busy_cnt <= total;
    end
  end

  // R8: the bar is always a thermometer code from bit 0 upward
  assert_bar_thermo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((NBAR'(bar_want + 1'b1)) & bar_want) == '0);

  // R9: the bar only moves when a window closes
  assert_bar_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(bar_want));

  // R9: the busy count never exceeds the elapsed window position
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= pos);

endmodule

// File: rtl/hub_led_panel.sv
module hub_led_panel
  import hub_led_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int HOLD_MS    = 40,
  parameter int WIN_CYCLES = 2500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic [NPORT-1:0] sig_det,
  input  logic [NPORT-1:0] idle_lock,
  input  logic [NPORT-1:0] rx_act,
  input  logic [NPORT-1:0] port_fault,
  input  logic [NPORT-1:0] bad_sym,
  input  logic             coll_local,
  input  logic             coll_stack,
  input  logic             net_busy,
  output logic [NPORT-1:0] act_led_n,
  output logic [NPORT-1:0] err_led_n,
  output logic             coll_led_n,
  output logic [NBAR-1:0]  util_led_n
);
  logic [NPORT-1:0] act_want, err_want;
  logic [NBAR-1:0]  bar_want;
  logic             coll_pulse;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_led_map #(.HOLD_MS(HOLD_MS)) u_map (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .sig_det(sig_det[p]), .idle_lock(idle_lock[p]), .rx_act(rx_act[p]),
      .port_fault(port_fault[p]), .bad_sym(bad_sym[p]),
      .act_want(act_want[p]), .err_want(err_want[p])
    );
    led_hold #(.HOLD_MS(HOLD_MS)) u_act_hold (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .want(act_want[p]), .led_n(act_led_n[p])
    );
    led_hold #(.HOLD_MS(HOLD_MS)) u_err_hold (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .want(err_want[p]), .led_n(err_led_n[p])
    );
  end

  // R10: local and stack collisions share one blink
  led_flash #(.HOLD_MS(HOLD_MS)) u_coll_flash (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cond(coll_local | coll_stack), .pulse(coll_pulse)
  );

  led_hold #(.HOLD_MS(HOLD_MS)) u_coll_hold (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .want(coll_pulse), .led_n(coll_led_n)
  );

  util_meter #(.WIN_CYCLES(WIN_CYCLES)) u_meter (
    .clk(clk), .rst_n(rst_n), .net_busy(net_busy), .bar_want(bar_want)
  );

  for (genvar k = 0; k < NBAR; k++) begin : g_bar
    led_hold #(.HOLD_MS(HOLD_MS)) u_bar_hold (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .want(bar_want[k]), .led_n(util_led_n[k])
    );
  end

  // R10: the collision LED only lights after a reported collision
  assert_coll_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coll_led_n) |-> $past(coll_pulse));

endmodule

// File: tb/hub_led_panel_bench.sv
module hub_led_panel_bench;
  localparam int NPORT = 4;
  localparam int HOLD  = 4;
  localparam int WIN   = 800;
  localparam int NLED  = 2 * NPORT + 1 + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic [NPORT-1:0] sig_det = '0, idle_lock = '0, rx_act = '0, port_fault = '0, bad_sym = '0;
  logic coll_local = 1'b0, coll_stack = 1'b0, net_busy = 1'b0;
  logic [NPORT-1:0] act_led_n, err_led_n;
  logic coll_led_n;
  logic [4:0] util_led_n;

  int checks = 0, bad = 0;
  bit done = 0;

  hub_led_panel #(.NPORT(NPORT), .HOLD_MS(HOLD), .WIN_CYCLES(WIN)) u_hub_led_panel (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .sig_det(sig_det), .idle_lock(idle_lock), .rx_act(rx_act),
    .port_fault(port_fault), .bad_sym(bad_sym),
    .coll_local(coll_local), .coll_stack(coll_stack), .net_busy(net_busy),
    .act_led_n(act_led_n), .err_led_n(err_led_n), .coll_led_n(coll_led_n),
    .util_led_n(util_led_n)
  );

  always #2 clk = ~clk;

  // tick every fourth cycle
  int tcnt = 0;
  always @(negedge clk) begin
    if (rst_n) tcnt <= tcnt + 1;
    ms_tick <= rst_n && ((tcnt % 4) == 3);
  end

  // periodic busy pattern: busy_k busy cycles out of every busy_per
  bit busy_en = 0;
  int busy_per = 1, busy_k = 0, bp = 0;
  always @(negedge clk) begin
    if (busy_en) begin
      bp = (bp + 1) % busy_per;
      net_busy <= (bp < busy_k);
    end else begin
      net_busy <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 monitor: ticks between output changes
  logic [NLED-1:0] prev_leds;
  int  ticks [NLED];
  bit  seen [NLED];
  always @(negedge clk) begin
    logic [NLED-1:0] now_leds;
    now_leds = {util_led_n, coll_led_n, err_led_n, act_led_n};
    if (!rst_n) begin
      prev_leds = now_leds;
      for (int i = 0; i < NLED; i++) begin ticks[i] = 0; seen[i] = 0; end
    end else begin
      for (int i = 0; i < NLED; i++) begin
        if (now_leds[i] != prev_leds[i]) begin
          if (seen[i]) check(ticks[i] >= HOLD, "R2 hold ticks", ticks[i], HOLD);
          seen[i] = 1;
          ticks[i] = ms_tick ? 1 : 0;
        end else if (ms_tick) begin
          ticks[i] = ticks[i] + 1;
        end
      end
      prev_leds = now_leds;
    end
  end

  function automatic logic [4:0] exp_bar(input int busy, input int win);
    real pct;
    logic [4:0] b;
    pct = 100.0 * busy / win;
    b[0] = pct > 1.0;
    b[1] = pct > 12.5;
    b[2] = pct > 25.0;
    b[3] = pct > 50.0;
    b[4] = pct > 60.0;
    return b;
  endfunction

  // port state codes: 0 none, 1 no lock, 2 linked idle, 3 receiving, 4 fault, 5 bad symbols
  task automatic set_port(input int p, input int s);
    sig_det[p]    = (s != 0);
    idle_lock[p]  = (s >= 2);
    rx_act[p]     = (s == 3);
    port_fault[p] = (s == 4);
    bad_sym[p]    = (s == 5);
  endtask

  function automatic logic [1:0] exp_steady(input int s); // {act_n, err_n}
    case (s)
      0:       return 2'b11;
      2:       return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic run_util(input int per, input int k);
    logic [4:0] e;
    busy_per = per; busy_k = k; busy_en = 1;
    repeat (3 * WIN + 50) @(negedge clk);
    e = exp_bar((WIN / per) * k, WIN);
    check(util_led_n == ~e, $sformatf("R8 R9 bar per=%0d k=%0d", per, k), util_led_n, ~e);
  endtask

  // count transitions and lit cycles of one LED over n cycles
  task automatic watch(input int idx, input int n, output int flips, output int low_cyc);
    logic v, pv;
    flips = 0; low_cyc = 0;
    pv = {util_led_n, coll_led_n, err_led_n, act_led_n}[idx];
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      v = {util_led_n, coll_led_n, err_led_n, act_led_n}[idx];
      if (v != pv) flips++;
      if (!v) low_cyc++;
      pv = v;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int f, lc;
    void'($urandom(32'h1d5));
    repeat (5) @(negedge clk);
    // R1: dark under reset
    check({util_led_n, coll_led_n, err_led_n, act_led_n} == '1, "R1 reset dark",
          {util_led_n, coll_led_n, err_led_n, act_led_n}, {NLED{1'b1}});
    busy_per = 1; busy_k = 1; busy_en = 1;
    rst_n = 1'b1;
    @(negedge clk);
    check({util_led_n, coll_led_n, err_led_n, act_led_n} == '1, "R1 after release",
          {util_led_n, coll_led_n, err_led_n, act_led_n}, {NLED{1'b1}});
    // R9: full busy, bar unchanged before the first window closes
    repeat (789) @(negedge clk);
    check(util_led_n == 5'h1f, "R9 before window end", util_led_n, 5'h1f);
    repeat (15) @(negedge clk);
    check(util_led_n == 5'h00, "R9 after window end", util_led_n, 5'h00);

    // R3 / R5 / R6 steady states
    for (int p = 0; p < NPORT; p++) set_port(p, 2);
    repeat (150) @(negedge clk);
    check(act_led_n == '0 && err_led_n == '1, "R5 linked idle", {act_led_n, err_led_n}, 8'h0f);

    // R5: receiving blinks activity dark
    set_port(1, 3);
    watch(1, 300, f, lc);
    check(f >= 3 && lc < 300, "R5 rx blink", f, 3);
    check(err_led_n[1] == 1'b1, "R5 err dark while rx", err_led_n[1], 1);

    // R4 / R11: no lock, error blinks, activity dark
    set_port(2, 1);
    repeat (60) @(negedge clk);
    watch(NPORT + 2, 300, f, lc);
    check(f >= 3, "R4 err blinks without lock", f, 3);
    check(lc >= 2 * HOLD * 4 && lc <= 300 - 2 * HOLD * 4, "R11 blink duty", lc, 150);
    check(act_led_n[2] == 1'b1, "R4 act dark without lock", act_led_n[2], 1);

    // R7: bad symbols blink error on
    set_port(3, 5);
    watch(NPORT + 3, 300, f, lc);
    check(f >= 3 && lc > 0, "R7 err blink on bad data", f, 3);
    check(act_led_n[3] == 1'b0, "R7 act lit with bad data", act_led_n[3], 0);

    // R6 and R3
    set_port(0, 4);
    set_port(1, 0);
    set_port(2, 2);
    set_port(3, 2);
    repeat (150) @(negedge clk);
    watch(0, 100, f, lc);
    check(f == 0 && act_led_n[0] == 1'b0 && err_led_n[0] == 1'b0, "R6 fault both lit",
          {act_led_n[0], err_led_n[0]}, 0);
    check(act_led_n[1] == 1'b1 && err_led_n[1] == 1'b1, "R3 no signal dark",
          {act_led_n[1], err_led_n[1]}, 3);
    check(err_led_n[3] == 1'b1, "R7 err dark after bad data stops", err_led_n[3], 1);

    // R10: collisions from either source
    check(coll_led_n == 1'b1, "R10 idle dark", coll_led_n, 1);
    coll_local = 1'b1; @(negedge clk); coll_local = 1'b0;
    watch(2 * NPORT, 30, f, lc);
    check(lc > 0, "R10 local collision lights", lc, 1);
    repeat (100) @(negedge clk);
    check(coll_led_n == 1'b1, "R10 dark after local", coll_led_n, 1);
    coll_stack = 1'b1; @(negedge clk); coll_stack = 1'b0;
    watch(2 * NPORT, 30, f, lc);
    check(lc > 0, "R10 stack collision lights", lc, 1);
    repeat (100) @(negedge clk);
    check(coll_led_n == 1'b1, "R10 dark after stack", coll_led_n, 1);

    // random port states
    for (int t = 0; t < 8; t++) begin
      int st [NPORT];
      for (int p = 0; p < NPORT; p++) begin
        st[p] = 2 * $urandom_range(0, 2);
        set_port(p, st[p]);
      end
      repeat (150) @(negedge clk);
      for (int p = 0; p < NPORT; p++)
        check({act_led_n[p], err_led_n[p]} == exp_steady(st[p]),
              $sformatf("R3 R5 R6 random port %0d state %0d", p, st[p]),
              {act_led_n[p], err_led_n[p]}, exp_steady(st[p]));
    end

    // R8 thresholds, exact boundaries and one step above
    run_util(100, 1);
    run_util(100, 2);
    run_util(80, 10);
    run_util(80, 11);
    run_util(80, 20);
    run_util(80, 21);
    run_util(80, 40);
    run_util(80, 41);
    run_util(80, 48);
    run_util(80, 49);
    run_util(80, 0);
    for (int t = 0; t < 6; t++) run_util(80, $urandom_range(0, 80));

    finish_up();
  end
endmodule